// File: doc/BRIEF.md
# Interrupt Request Latch Register

This block holds the pending flags of six interrupt sources for a small 8-bit microcontroller core. Each source delivers a one-cycle request pulse that is already synchronous to the clock. The pulse sets that source's flag, and the flag stays set until the CPU clears it. The CPU reaches the register through a plain register-file port: a write strobe with address and data, and a combinational read port for the same address. A pending vector goes out to the interrupt logic downstream. A global-enable flag is kept here as well, and the enable-interrupts and disable-interrupts strobes drive it.

After reset the register is cleared and locked. While it is locked, it throws away request pulses and ignores CPU writes, so it reads as zero. The first enable-interrupts strobe unlocks it, and it then stays unlocked until the next reset. A CPU write to any other address does not unlock it. This includes a write that sets the global-enable bit of the mask register. Code that only polls must therefore still issue one enable-interrupts strobe. The two top bits are plain CPU storage bits, and requests never touch them.

Top module: `irq_pending_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the register reads 0x00 at address 0xFA, the pending vector is 0 and global enable is 0.
- R2: The register lives at address 0xFA. A read there returns the storage bits in bits 7:6 and the pending flags in bits 5:0, where bit i belongs to source i. A read at any other address returns 0x00.
- R3: A request pulse that arrives while the register is locked is discarded. It is not set later, even after an unlock.
- R4: While the register is locked, CPU writes to 0xFA have no effect. A write to another address, such as 0xFB with bit 7 set, does not unlock the register.
- R5: An enable-interrupts strobe unlocks the register from the next cycle onward. A request or a write presented in the same cycle as the strobe is still ignored.
- R6: While the register is unlocked, a request pulse on source i sets bit i on the next clock edge. The bit stays set until a CPU write clears it.
- R7: While the register is unlocked, a CPU write to 0xFA loads all eight bits from the write data on the next edge.
- R8: When a request on source i and a CPU write that clears bit i fall in the same cycle, bit i ends up set.
- R9: Bits 7:6 reset to 0, change only on a CPU write to 0xFA while unlocked, and are never altered by requests.
- R10: Global enable is set by an enable-interrupts strobe and cleared by a disable-interrupts strobe. If both strobes arrive in the same cycle, global enable is cleared. A disable strobe does not relock the register.
- R11: Once unlocked, the register stays unlocked until the next reset, and that reset locks it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 6 | One-cycle request pulses, one per source |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| wr_en_i | input | 1 | CPU register-file write strobe |
| addr_i | input | 8 | CPU register-file address |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| pending_o | output | 6 | Pending flags, bit i for source i |
| global_en_o | output | 1 | Global interrupt enable flag |

## Verification
The bench builds the block with its default parameters: six sources, an 8-bit data path and the register at address 0xFA. With these values every source bit, both storage bits and the neighbouring mask-register address 0xFB can be driven directly. A directed sequence walks a single request through each source. It also lands collisions between a request and a clearing write, the enable and disable strobes in one cycle, and writes during the unlock cycle. A behavioural model, compared on every clock, covers the lock, unlock and relock after reset.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt request latch register.
// Assumes an 8-bit register file with the request register at one fixed address.
package irq_pkg;
    localparam int unsigned IRQ_SRC_N   = 6;
    localparam int unsigned IRQ_DATA_W  = 8;
    localparam int unsigned IRQ_ADDR_W  = 8;
    localparam logic [7:0]  IRQ_REG_ADR = 8'hFA;
endpackage

// File: rtl/irq_unlock_ctrl.sv
// Module: irq_unlock_ctrl
// Keeps the one-way unlock flag and the global interrupt enable flag.
// Assumes ei_i and di_i are single-cycle strobes synchronous to clk.
module irq_unlock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    output logic unlocked_o,
    output logic gie_o
);
    logic unlocked_q;
    logic gie_q;

    // Unlock flag: set by the first EI strobe, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    unlocked_q <= 1'b0;
        else if (ei_i) unlocked_q <= 1'b1;
    end

    // Global enable: DI wins over EI when both arrive together.
    always_ff @(posedge clk) begin
        if (!rst_n)    gie_q <= 1'b0;
        else if (di_i) gie_q <= 1'b0;
        else if (ei_i) gie_q <= 1'b1;
    end

    assign unlocked_o = unlocked_q;
    assign gie_o      = gie_q;
endmodule

// File: rtl/irq_pend_bit.sv
// Module: irq_pend_bit
// One pending flag. It is frozen while locked. Once unlocked, a request sets
// it and a CPU write loads it, with the request taking priority.
// Assumes req_i is a synchronized single-cycle pulse.
module irq_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic unlocked_i,
    input  logic req_i,
    input  logic wr_hit_i,
    input  logic wr_bit_i,
    output logic pend_o
);
    logic pend_q;

    // Pending flag update: request OR (written value or held value).
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (unlocked_i) pend_q <= req_i | (wr_hit_i ? wr_bit_i : pend_q);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_cfg_store.sv
// Module: irq_cfg_store
// Plain CPU storage for the register's upper bits; requests never reach it.
// Assumes load_i already includes the unlock qualification.
module irq_cfg_store #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Storage update: load on qualified CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (load_i) q <= data_i;
    end

    assign q_o = q;
endmodule

// File: rtl/irq_pending_reg.sv
// Module: irq_pending_reg (top)
// Interrupt request latch register at one register-file address. It is locked
// and cleared after reset and unlocked by the first EI strobe.
// Assumes request pulses are synchronized and one cycle wide.
module irq_pending_reg #(
    parameter int unsigned NUM_SRC  = irq_pkg::IRQ_SRC_N,
    parameter int unsigned DATA_W   = irq_pkg::IRQ_DATA_W,
    parameter int unsigned ADDR_W   = irq_pkg::IRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = irq_pkg::IRQ_REG_ADR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               global_en_o
);
    localparam int unsigned CFG_W = DATA_W - NUM_SRC;

    logic              unlocked_w;
    logic              addr_hit;
    logic              wr_hit;
    logic [DATA_W-1:0] reg_val;

    // Address decode for the single register.
    assign addr_hit = (addr_i == REG_ADDR);
    assign wr_hit   = wr_en_i && addr_hit;

    irq_unlock_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .unlocked_o (unlocked_w),
        .gie_o      (global_en_o)
    );

    // One pending cell per request source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        irq_pend_bit u_bit (
            .clk        (clk),
            .rst_n      (rst_n),
            .unlocked_i (unlocked_w),
            .req_i      (req_i[i]),
            .wr_hit_i   (wr_hit),
            .wr_bit_i   (wr_data_i[i]),
            .pend_o     (pending_o[i])
        );
    end

    // Upper storage bits exist only when the data path is wider than the sources.
    if (CFG_W > 0) begin : g_cfg
        logic [CFG_W-1:0] cfg_q;
        irq_cfg_store #(.W(CFG_W)) u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (wr_hit && unlocked_w),
            .data_i (wr_data_i[DATA_W-1:NUM_SRC]),
            .q_o    (cfg_q)
        );
        assign reg_val = {cfg_q, pending_o};
    end else begin : g_nocfg
        assign reg_val = pending_o;
    end

    // Read mux: register contents at its address, zero elsewhere.
    assign rd_data_o = addr_hit ? reg_val : '0;
endmodule

// File: rtl/irq_pending_reg_chk.sv
// Module: irq_pending_reg_chk
// Assertion checker bound to irq_pending_reg. It watches the ports and the
// internal unlock flag.
module irq_pending_reg_chk #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFA
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input logic               ei_i,
    input logic               di_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic [NUM_SRC-1:0] pending_o,
    input logic               global_en_o,
    input logic               unlocked
);
    logic hit;
    assign hit = wr_en_i && (addr_i == REG_ADDR);

    p_locked_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> (pending_o == '0));

    p_sticky_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    p_ei_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ei_i |=> unlocked);

    p_req_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !hit) |=> ((pending_o & $past(req_i)) == $past(req_i)));

    p_req_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && hit) |=> ((pending_o & $past(req_i)) == $past(req_i)));

    p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && hit && req_i == '0) |=> (rd_data_o == $past(wr_data_i) || addr_i != REG_ADDR));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && req_i == '0) |=> $stable(pending_o));

    p_di_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !global_en_o);

    p_ei_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_i && !di_i) |=> global_en_o);

    p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != REG_ADDR) |-> (rd_data_o == '0));
endmodule

bind irq_pending_reg irq_pending_reg_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .pending_o  (pending_o),
    .global_en_o(global_en_o),
    .unlocked   (unlocked_w)
);

// File: tb/irq_pending_reg_test.sv
// Bench: directed stimulus and a behavioural reference model that is compared on every clock.
module irq_pending_reg_test;
    localparam logic [7:0] RA = 8'hFA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req = '0;
    logic       ei = 1'b0, di = 1'b0, we = 1'b0;
    logic [7:0] addr = RA, wd = '0;
    logic [7:0] rd_data;
    logic [5:0] pending;
    logic       gie;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_unl = 0;
    bit       m_gie = 0;
    bit [7:0] m_reg = '0;

    always #5 clk = ~clk;

    irq_pending_reg uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ei_i(ei), .di_i(di),
        .wr_en_i(we), .addr_i(addr), .wr_data_i(wd),
        .rd_data_o(rd_data), .pending_o(pending), .global_en_o(gie)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Advance one clock with the given inputs, update the model, compare at the negedge.
    task automatic cyc(input logic [5:0] r, input logic e, input logic d,
                       input logic w, input logic [7:0] a, input logic [7:0] x);
        bit [7:0] nxt;
        req = r; ei = e; di = d; we = w; addr = a; wd = x;
        @(posedge clk);
        if (!rst_n) begin
            m_unl = 0; m_gie = 0; m_reg = '0;
        end else begin
            if (m_unl) begin
                nxt = (w && a == RA) ? x : m_reg;
                nxt[5:0] = nxt[5:0] | r;
                m_reg = nxt;
            end
            if (e) m_unl = 1;
            if (d) m_gie = 0;
            else if (e) m_gie = 1;
        end
        @(negedge clk);
        chk("MODEL(R2) rd", rd_data, (a == RA) ? m_reg : 8'h00);
        chk("MODEL(R6) pending", {2'b00, pending}, {2'b00, m_reg[5:0]});
        chk("MODEL(R10) gie", {7'd0, gie}, {7'd0, m_gie});
    endtask

    task automatic idle(); cyc('0, 0, 0, 0, RA, '0); endtask
    task automatic wr(input logic [7:0] a, input logic [7:0] x); cyc('0, 0, 0, 1, a, x); endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        addr = a; we = 1'b0; req = '0; ei = 1'b0; di = 1'b0;
        #1 v = rd_data;
    endtask

    logic [7:0] v;

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) idle();
        chk("R1 reset rd", rd_data, 8'h00);
        rst_n = 1'b1;
        idle();
        chk("R1 after reset rd", rd_data, 8'h00);
        chk("R1 gie", {7'd0, gie}, 8'h00);

        // locked behaviour
        cyc(6'h3F, 0, 0, 0, RA, 0);
        chk("R3 locked request dropped", {2'b00, pending}, 8'h00);
        wr(RA, 8'hFF);
        chk("R4 locked write ignored", rd_data, 8'h00);
        wr(8'hFB, 8'h80);
        cyc(6'h01, 0, 0, 0, RA, 0);
        chk("R4 mask write does not unlock", rd_data, 8'h00);

        // unlock cycle: request and write in the same cycle are ignored
        cyc(6'h02, 1, 0, 1, RA, 8'h55);
        chk("R5 unlock cycle ignored", rd_data, 8'h00);
        chk("R10 ei sets gie", {7'd0, gie}, 8'h01);
        chk("R3 dropped request not held", {2'b00, pending}, 8'h00);
        cyc(6'h04, 0, 0, 0, RA, 0);
        chk("R5 unlocked next cycle", rd_data, 8'h04);

        // walk each source
        for (int i = 0; i < 6; i++) begin
            wr(RA, 8'h00);
            cyc(6'(1 << i), 0, 0, 0, RA, 0);
            chk("R2 bit position", rd_data, 8'(1 << i));
            idle();
            chk("R6 flag holds", {2'b00, pending}, 8'(1 << i));
        end

        wr(RA, 8'hC0);
        chk("R7 write loads all bits", rd_data, 8'hC0);
        cyc(6'h3F, 0, 0, 0, RA, 0);
        chk("R9 requests keep upper bits", rd_data, 8'hFF);
        wr(RA, 8'h00);
        cyc(6'h3F, 0, 0, 0, RA, 0);
        chk("R9 upper bits not set by requests", rd_data, 8'h3F);

        // collision
        cyc(6'h08, 0, 0, 1, RA, 8'h00);
        chk("R8 request beats clear", rd_data, 8'h08);

        peek(8'h10, v);
        chk("R2 other address reads zero", v, 8'h00);
        peek(8'hFB, v);
        chk("R2 neighbour reads zero", v, 8'h00);

        // global enable
        cyc('0, 0, 1, 0, RA, 0);
        chk("R10 di clears gie", {7'd0, gie}, 8'h00);
        wr(RA, 8'h00);
        cyc(6'h20, 0, 0, 0, RA, 0);
        chk("R10 di does not relock", rd_data, 8'h20);
        cyc('0, 1, 1, 0, RA, 0);
        chk("R10 di wins over ei", {7'd0, gie}, 8'h00);
        cyc('0, 1, 0, 0, RA, 0);
        chk("R10 ei sets again", {7'd0, gie}, 8'h01);

        // persistence then relock by reset
        repeat (20) idle();
        wr(RA, 8'h81);
        chk("R11 still unlocked", rd_data, 8'h81);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        wr(RA, 8'hFF);
        chk("R11 reset relocks", rd_data, 8'h00);
        cyc(6'h3F, 0, 0, 0, RA, 0);
        chk("R11 relocked drops requests", rd_data, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule